// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the command front end and write sequencer for a byte-wide, 256-Kbyte flash array that is split into five blocks of unequal size. A host issues bus writes made of address, data, chip enable and an active-low write strobe. The controller turns these writes into read-mode changes, single-byte program operations, whole-block erase operations, erase suspend and resume requests, and status clears. It starts each operation on the array through a start/done handshake, pauses an erase with a hold level, and cancels an operation with an abort pulse. Bus reads return array data, the status byte or an identifier byte.

One input, the reset level, has three values. Low resets the sequencer and puts the block in deep power-down. Normal high is ordinary operation with the top 16-Kbyte boot block locked. The high-voltage level unlocks the boot block. A second input reports whether the programming supply is above lockout. When it is not, every program or erase is refused.

A typical host places code in the boot block and changes it only while the high-voltage level is applied. It keeps frequently rewritten data in the two 8-Kbyte parameter blocks and bulk storage in the two main blocks.

Top module: `bbflash_ctrl`

## Requirements
- R1: Block decode is fixed. Addresses 3C000h–3FFFFh are the boot block (index 4), 3A000h–3BFFFh and 38000h–39FFFh are the two parameter blocks (3 and 2), 20000h–37FFFh is the 96-KB main block (1), and 00000h–1FFFFh is the 128-KB main block (0). An erase changes only the block that holds the confirm address.
- R2: Writing 40h and then a data byte programs that byte at the second write's address. The stored value becomes the old value AND the data, and the status reads 80h when the operation has finished.
- R3: Writing 20h and then D0h erases every byte of the addressed block to FFh.
- R4: An erase setup that is followed by any byte other than D0h sets status bits 5 and 4, starts no operation and returns to ready.
- R5: A program or erase aimed at the boot block is refused at the normal-high level (status bit 4 for a program, bit 5 for an erase, array unchanged). It runs at the high-voltage level.
- R6: If the level leaves high-voltage while a boot-block operation is running or suspended, the operation is aborted, its error bit is set and the byte is not changed.
- R7: With the supply flag low, program and erase are refused. Bit 3 is set together with bit 4 (program) or bit 5 (erase). Read array, read status, clear status and identifier reads still work.
- R8: A low reset level clears the status and the sequencer, holds data output at 00h and asserts `pwr_down`. After the level rises the block is in read-array mode.
- R9: Bus writes that complete within WAKE_CYC clock cycles after the level rises are ignored.
- R10: B0h during an erase suspends it: `arr_hold` goes high and the status reads C0h. D0h resumes the erase, which then completes. While suspended, FFh/70h/90h change the read mode.
- R11: While an operation is running, a read returns the status byte with bit 7 low, whatever read mode was last selected.
- R12: Error bits 5, 4 and 3 stay set until 50h clears them.
- R13: After 90h, a read with address bit 0 low returns MFR_ID (default A5h) and with bit 0 high returns DEV_ID (default 3Ch). FFh returns to array reads and 70h selects status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rp_lvl | input | 2 | Reset level: 00 low, 01 normal high, 1x high-voltage |
| vpp_ok | input | 1 | Programming supply above lockout |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; captured on its rising edge |
| addr | input | 18 | Bus byte address |
| din | input | 8 | Bus write data |
| dq_o | output | 8 | Bus read data (00h when not driven) |
| arr_rdata | input | 8 | Array read data for `arr_raddr` |
| arr_done | input | 1 | Array reports the current operation finished |
| arr_raddr | output | 18 | Array read address |
| arr_start | output | 1 | One-cycle pulse starting an array operation |
| arr_erase | output | 1 | Operation kind: 1 erase, 0 program |
| arr_op_addr | output | 18 | Operation byte address |
| arr_op_data | output | 8 | Program data |
| arr_op_blk | output | 3 | Operation block index |
| arr_hold | output | 1 | Pause the running erase |
| arr_abort | output | 1 | One-cycle pulse cancelling the operation |
| pwr_down | output | 1 | Deep power-down indication |

## Verification
Two events can land in the same clock cycle: an erase-suspend write and the array's done indication for that erase. The bench stops the array model's own completion, times a B0h bus write so that it is captured in the cycle before the done pulse is raised, and raises done one cycle later. Completion must win. Afterwards the status must read 80h with the suspend bit clear, `arr_hold` must be low and the block must be erased. Randomised programs to all five blocks at both unlocked and locked levels are compared against a reference byte map.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int BW = 3;

    typedef enum logic [2:0] {ST_RDY, ST_PSET, ST_ESET, ST_PBSY, ST_EBSY, ST_ESUS} seq_st_e;
    typedef enum logic [1:0] {RM_ARR, RM_STAT, RM_ID} rd_mode_e;

    localparam logic [BW-1:0] BLK_MAIN0 = 3'd0;
    localparam logic [BW-1:0] BLK_MAIN1 = 3'd1;
    localparam logic [BW-1:0] BLK_PARA0 = 3'd2;
    localparam logic [BW-1:0] BLK_PARA1 = 3'd3;
    localparam logic [BW-1:0] BLK_BOOT  = 3'd4;

    localparam logic [DW-1:0] CMD_RDARR = 8'hFF;
    localparam logic [DW-1:0] CMD_PROG  = 8'h40;
    localparam logic [DW-1:0] CMD_ERASE = 8'h20;
    localparam logic [DW-1:0] CMD_CONF  = 8'hD0;
    localparam logic [DW-1:0] CMD_RDST  = 8'h70;
    localparam logic [DW-1:0] CMD_CLRST = 8'h50;
    localparam logic [DW-1:0] CMD_RDID  = 8'h90;
    localparam logic [DW-1:0] CMD_SUSP  = 8'hB0;

    function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
        if (a >= 18'h3C000)      return BLK_BOOT;
        else if (a >= 18'h3A000) return BLK_PARA1;
        else if (a >= 18'h38000) return BLK_PARA0;
        else if (a >= 18'h20000) return BLK_MAIN1;
        else                     return BLK_MAIN0;
    endfunction
endpackage

// File: rtl/bbf_busif.sv
module bbf_busif
    import bbf_pkg::*;
#(
    parameter int WAKE_CYC = 8
) (
    input  logic          clk,
    input  logic          pd,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_vld,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic          we_s;
        logic [CW-1:0] cnt;
        logic          vld;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } bus_t;

    bus_t q, d;

    always_comb begin
        d      = q;
        d.we_s = we_n;
        d.vld  = 1'b0;
        if (q.cnt != CW'(WAKE_CYC)) d.cnt = q.cnt + 1'b1;
        // rising strobe edge with chip enabled, only once awake
        if (!q.we_s && we_n && !ce_n && (q.cnt == CW'(WAKE_CYC))) begin
            d.vld = 1'b1;
            d.a   = addr;
            d.d   = din;
        end
    end

    always_ff @(posedge clk) begin
        if (pd) begin
            q <= '0;
            q.we_s <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_vld  = q.vld;
    assign wr_addr = q.a;
    assign wr_data = q.d;
endmodule

// File: rtl/bbf_seq.sv
module bbf_seq
    import bbf_pkg::*;
(
    input  logic          clk,
    input  logic          pd,
    input  logic          hv,
    input  logic          vpp_ok,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          arr_done,
    output logic          busy,
    output rd_mode_e      rmode,
    output logic [DW-1:0] status,
    output logic          arr_start,
    output logic          arr_erase,
    output logic          arr_hold,
    output logic          arr_abort,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [BW-1:0] op_blk
);
    typedef struct packed {
        seq_st_e       st;
        rd_mode_e      rm;
        logic          err_e;
        logic          err_p;
        logic          err_v;
        logic          start;
        logic          erase;
        logic          hold;
        logic          abort;
        logic [AW-1:0] oa;
        logic [DW-1:0] od;
        logic [BW-1:0] ob;
    } seq_t;

    seq_t q, d;
    logic lock_run;

    assign lock_run = !vpp_ok || ((q.ob == BLK_BOOT) && !hv);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        case (q.st)
            ST_RDY: if (wr_vld) begin
                case (wr_data)
                    CMD_RDARR: d.rm = RM_ARR;
                    CMD_RDST:  d.rm = RM_STAT;
                    CMD_RDID:  d.rm = RM_ID;
                    CMD_CLRST: begin d.err_e = 1'b0; d.err_p = 1'b0; d.err_v = 1'b0; end
                    CMD_PROG:  begin d.st = ST_PSET; d.rm = RM_STAT; end
                    CMD_ERASE: begin d.st = ST_ESET; d.rm = RM_STAT; end
                    default: ;
                endcase
            end
            ST_PSET, ST_ESET: if (wr_vld) begin
                d.oa    = wr_addr;
                d.od    = wr_data;
                d.ob    = blk_of(wr_addr);
                d.erase = (q.st == ST_ESET);
                d.st    = ST_RDY;
                if ((q.st == ST_ESET) && (wr_data != CMD_CONF)) begin
                    d.err_e = 1'b1;
                    d.err_p = 1'b1;
                end else if (!vpp_ok || ((blk_of(wr_addr) == BLK_BOOT) && !hv)) begin
                    if (!vpp_ok) d.err_v = 1'b1;
                    if (q.st == ST_ESET) d.err_e = 1'b1;
                    else                 d.err_p = 1'b1;
                end else begin
                    d.start = 1'b1;
                    d.st    = (q.st == ST_ESET) ? ST_EBSY : ST_PBSY;
                end
            end
            default: begin
                if (lock_run) begin
                    d.abort = 1'b1;
                    d.hold  = 1'b0;
                    d.st    = ST_RDY;
                    if (!vpp_ok) d.err_v = 1'b1;
                    if (q.erase) d.err_e = 1'b1;
                    else         d.err_p = 1'b1;
                end else if ((q.st != ST_ESUS) && arr_done) begin
                    d.st = ST_RDY;
                end else if (wr_vld) begin
                    case (wr_data)
                        CMD_RDARR: d.rm = RM_ARR;
                        CMD_RDST:  d.rm = RM_STAT;
                        CMD_RDID:  d.rm = RM_ID;
                        CMD_SUSP:  if (q.st == ST_EBSY) begin
                            d.st   = ST_ESUS;
                            d.hold = 1'b1;
                            d.rm   = RM_STAT;
                        end
                        CMD_CONF:  if (q.st == ST_ESUS) begin
                            d.st   = ST_EBSY;
                            d.hold = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (pd) q <= '0;
        else    q <= d;
    end

    assign busy      = (q.st == ST_PBSY) || (q.st == ST_EBSY);
    assign rmode     = q.rm;
    assign status    = {!busy, (q.st == ST_ESUS), q.err_e, q.err_p, q.err_v, 3'b000};
    assign arr_start = q.start;
    assign arr_erase = q.erase;
    assign arr_hold  = q.hold;
    assign arr_abort = q.abort;
    assign op_addr   = q.oa;
    assign op_data   = q.od;
    assign op_blk    = q.ob;
endmodule

// File: rtl/bbf_rdmux.sv
module bbf_rdmux
    import bbf_pkg::*;
#(
    parameter logic [DW-1:0] MFR_ID = 8'hA5,
    parameter logic [DW-1:0] DEV_ID = 8'h3C
) (
    input  logic          pd,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          busy,
    input  rd_mode_e      rmode,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] arr_rdata,
    input  logic          a0,
    output logic [DW-1:0] dq
);
    always_comb begin
        dq = '0;
        if (!pd && !ce_n && !oe_n) begin
            if (busy) dq = status;
            else begin
                case (rmode)
                    RM_ARR:  dq = arr_rdata;
                    RM_STAT: dq = status;
                    RM_ID:   dq = a0 ? DEV_ID : MFR_ID;
                    default: dq = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/bbflash_ctrl.sv
module bbflash_ctrl
    import bbf_pkg::*;
#(
    parameter int            WAKE_CYC = 8,
    parameter logic [DW-1:0] MFR_ID   = 8'hA5,
    parameter logic [DW-1:0] DEV_ID   = 8'h3C
) (
    input  logic          clk,
    input  logic [1:0]    rp_lvl,
    input  logic          vpp_ok,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dq_o,
    input  logic [DW-1:0] arr_rdata,
    input  logic          arr_done,
    output logic [AW-1:0] arr_raddr,
    output logic          arr_start,
    output logic          arr_erase,
    output logic [AW-1:0] arr_op_addr,
    output logic [DW-1:0] arr_op_data,
    output logic [BW-1:0] arr_op_blk,
    output logic          arr_hold,
    output logic          arr_abort,
    output logic          pwr_down
);
    logic          pd, hv, wr_vld, busy;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data, status;
    rd_mode_e      rmode;

    assign pd        = (rp_lvl == 2'b00);
    assign hv        = rp_lvl[1];
    assign pwr_down  = pd;
    assign arr_raddr = addr;

    bbf_busif #(.WAKE_CYC(WAKE_CYC)) u_bus (
        .clk(clk), .pd(pd), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    bbf_seq u_seq (
        .clk(clk), .pd(pd), .hv(hv), .vpp_ok(vpp_ok),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .arr_done(arr_done),
        .busy(busy), .rmode(rmode), .status(status),
        .arr_start(arr_start), .arr_erase(arr_erase), .arr_hold(arr_hold),
        .arr_abort(arr_abort), .op_addr(arr_op_addr), .op_data(arr_op_data),
        .op_blk(arr_op_blk)
    );

    bbf_rdmux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .pd(pd), .ce_n(ce_n), .oe_n(oe_n), .busy(busy), .rmode(rmode),
        .status(status), .arr_rdata(arr_rdata), .a0(addr[0]), .dq(dq_o)
    );
endmodule

// File: rtl/bbf_chk.sv
module bbf_chk
    import bbf_pkg::*;
(
    input logic          clk,
    input logic [1:0]    rp_lvl,
    input logic          vpp_ok,
    input logic          pwr_down,
    input logic          ce_n,
    input logic          oe_n,
    input logic [DW-1:0] dq_o,
    input logic          arr_start,
    input logic          arr_hold,
    input logic [BW-1:0] arr_op_blk,
    input logic          busy
);
    // R5
    boot_unlock_chk: assert property (@(posedge clk) disable iff (pwr_down)
        (arr_start && (arr_op_blk == BLK_BOOT)) |-> rp_lvl[1]);

    // R7
    supply_gate_chk: assert property (@(posedge clk) disable iff (pwr_down)
        arr_start |-> vpp_ok);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (pwr_down)
        arr_start |=> !arr_start);

    // R8
    pd_quiet_chk: assert property (@(posedge clk)
        pwr_down |=> (!arr_hold && !arr_start));

    // R11
    busy_read_chk: assert property (@(posedge clk) disable iff (pwr_down)
        (busy && !ce_n && !oe_n) |-> (dq_o[7] == 1'b0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (pwr_down)
        arr_hold |-> !busy);
endmodule

bind bbflash_ctrl bbf_chk u_chk (
    .clk(clk), .rp_lvl(rp_lvl), .vpp_ok(vpp_ok), .pwr_down(pwr_down),
    .ce_n(ce_n), .oe_n(oe_n), .dq_o(dq_o), .arr_start(arr_start),
    .arr_hold(arr_hold), .arr_op_blk(arr_op_blk), .busy(busy)
);

// File: tb/tb_bbflash_ctrl.sv
`timescale 1ns/1ps
module tb_bbflash_ctrl;
    logic        clk = 1'b0;
    logic [1:0]  rp_lvl = 2'b00;
    logic        vpp_ok = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_o, arr_rdata, arr_op_data;
    logic        arr_done, arr_start, arr_erase, arr_hold, arr_abort, pwr_down;
    logic [17:0] arr_raddr, arr_op_addr;
    logic [2:0]  arr_op_blk;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bbflash_ctrl dut (
        .clk(clk), .rp_lvl(rp_lvl), .vpp_ok(vpp_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .din(din), .dq_o(dq_o), .arr_rdata(arr_rdata),
        .arr_done(arr_done), .arr_raddr(arr_raddr), .arr_start(arr_start),
        .arr_erase(arr_erase), .arr_op_addr(arr_op_addr), .arr_op_data(arr_op_data),
        .arr_op_blk(arr_op_blk), .arr_hold(arr_hold), .arr_abort(arr_abort),
        .pwr_down(pwr_down)
    );

    // ---------------- behavioural array ----------------
    logic [7:0] mem [int];
    int  gen = 0;
    bit  active = 0, op_er = 0, manual = 0, done_man = 0;
    int  rem = 0, lat = 6;
    logic [17:0] o_a;
    logic [7:0]  o_d;

    function automatic void blk_range(input int a, output int lo, output int hi);
        if (a >= 'h3C000)      begin lo = 'h3C000; hi = 'h3FFFF; end
        else if (a >= 'h3A000) begin lo = 'h3A000; hi = 'h3BFFF; end
        else if (a >= 'h38000) begin lo = 'h38000; hi = 'h39FFF; end
        else if (a >= 'h20000) begin lo = 'h20000; hi = 'h37FFF; end
        else                   begin lo = 'h00000; hi = 'h1FFFF; end
    endfunction

    assign arr_done = active && ((!manual && !arr_hold && rem == 0) || (manual && done_man));

    always @(arr_raddr or gen)
        arr_rdata = mem.exists(int'(arr_raddr)) ? mem[int'(arr_raddr)] : 8'hFF;

    always @(posedge clk) begin
        if (pwr_down || arr_abort) begin
            active <= 0;
        end else if (active && arr_done) begin
            if (op_er) begin
                int lo, hi;
                blk_range(int'(o_a), lo, hi);
                for (int a = lo; a <= hi; a++) if (mem.exists(a)) mem.delete(a);
            end else begin
                mem[int'(o_a)] = (mem.exists(int'(o_a)) ? mem[int'(o_a)] : 8'hFF) & o_d;
            end
            gen <= gen + 1;
            active <= 0;
        end else if (arr_start) begin
            active <= 1; rem <= lat; op_er <= arr_erase; o_a <= arr_op_addr; o_d <= arr_op_data;
        end else if (active && !arr_hold && rem > 0) begin
            rem <= rem - 1;
        end
    end

    // ---------------- reference byte map ----------------
    logic [7:0] refm [int];
    function automatic logic [7:0] exp_rd(input int a);
        return refm.exists(a) ? refm[a] : 8'hFF;
    endfunction
    function automatic void ref_prog(input int a, input logic [7:0] d);
        refm[a] = exp_rd(a) & d;
    endfunction
    function automatic void ref_erase(input int a);
        int lo, hi;
        blk_range(a, lo, hi);
        for (int i = lo; i <= hi; i++) if (refm.exists(i)) refm.delete(i);
    endfunction

    // ---------------- tasks ----------------
    task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        #1 v = dq_o;
        oe_n = 1; ce_n = 1;
    endtask

    task automatic wait_rdy(output logic [7:0] st);
        st = 8'h00;
        while (!st[7]) rd(18'h0, st);
    endtask

    task automatic prog(input logic [17:0] a, input logic [7:0] d, output logic [7:0] st);
        wr(a, 8'h40); wr(a, d); wait_rdy(st);
    endtask

    task automatic erase(input logic [17:0] a, output logic [7:0] st);
        wr(a, 8'h20); wr(a, 8'hD0); wait_rdy(st);
    endtask

    task automatic power_up();
        @(negedge clk); rp_lvl = 2'b01;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);

        // R8: reset state
        @(negedge clk); ce_n = 0; oe_n = 0; #1;
        ck("R8 dq in power-down", dq_o, 8'h00);
        ck("R8 pwr_down", pwr_down, 1);
        ck("R8 hold idle", arr_hold, 0);
        oe_n = 1; ce_n = 1;

        // R9: write during wake-up ignored
        @(negedge clk); rp_lvl = 2'b01;
        wr(18'h0, 8'h90);
        rd(18'h0, v);
        ck("R9 early write ignored", v, 8'hFF);
        repeat (12) @(negedge clk);
        wr(18'h0, 8'h90);
        rd(18'h0, v); ck("R13 manufacturer id", v, 8'hA5);
        rd(18'h1, v); ck("R13 device id", v, 8'h3C);

        // R2: program
        prog(18'h00100, 8'h5A, st); ref_prog('h100, 8'h5A);
        ck("R2 status after program", st, 8'h80);
        wr(18'h0, 8'hFF);
        rd(18'h00100, v); ck("R2 programmed byte", v, exp_rd('h100));
        prog(18'h00100, 8'h0F, st); ref_prog('h100, 8'h0F);
        wr(18'h0, 8'hFF);
        rd(18'h00100, v); ck("R2 reprogram ANDs", v, 8'h0A);

        // R1/R3: erase one parameter block, neighbours kept
        prog(18'h38010, 8'h11, st); ref_prog('h38010, 8'h11);
        prog(18'h39FFF, 8'h22, st); ref_prog('h39FFF, 8'h22);
        prog(18'h37FFF, 8'h33, st); ref_prog('h37FFF, 8'h33);
        prog(18'h3A000, 8'h44, st); ref_prog('h3A000, 8'h44);
        erase(18'h38ABC, st); ref_erase('h38ABC);
        ck("R3 erase status", st, 8'h80);
        wr(18'h0, 8'hFF);
        rd(18'h38010, v); ck("R3 block low erased", v, 8'hFF);
        rd(18'h39FFF, v); ck("R1 block top erased", v, 8'hFF);
        rd(18'h37FFF, v); ck("R1 main neighbour kept", v, 8'h33);
        rd(18'h3A000, v); ck("R1 param neighbour kept", v, 8'h44);

        // R4/R12: bad confirm
        wr(18'h00100, 8'h20); wr(18'h00100, 8'h70);
        rd(18'h0, v); ck("R4 bad confirm status", v, 8'hB0);
        wr(18'h0, 8'h70);
        rd(18'h0, v); ck("R12 errors sticky", v, 8'hB0);
        wr(18'h0, 8'h50);
        rd(18'h0, v); ck("R12 cleared", v, 8'h80);
        wr(18'h0, 8'hFF);
        rd(18'h00100, v); ck("R4 array untouched", v, exp_rd('h100));

        // R5: boot block lock
        prog(18'h3C005, 8'h00, st);
        ck("R5 locked boot program", st, 8'h90);
        wr(18'h0, 8'h50);
        erase(18'h3C005, st);
        ck("R5 locked boot erase", st, 8'hA0);
        wr(18'h0, 8'h50);
        wr(18'h0, 8'hFF);
        rd(18'h3C005, v); ck("R5 boot unchanged", v, 8'hFF);
        @(negedge clk); rp_lvl = 2'b10;
        prog(18'h3C005, 8'h00, st); ref_prog('h3C005, 8'h00);
        ck("R5 unlocked program", st, 8'h80);
        wr(18'h0, 8'hFF);
        rd(18'h3C005, v); ck("R5 boot written", v, 8'h00);

        // R6: level drops during boot operation
        lat = 40;
        wr(18'h3D000, 8'h40); wr(18'h3D000, 8'h12);
        @(negedge clk); rp_lvl = 2'b01;
        wait_rdy(st);
        ck("R6 abort status", st, 8'h90);
        wr(18'h0, 8'h50); wr(18'h0, 8'hFF);
        rd(18'h3D000, v); ck("R6 byte unchanged", v, 8'hFF);
        lat = 6;

        // R7: supply lockout
        @(negedge clk); vpp_ok = 0;
        prog(18'h00200, 8'h00, st);
        ck("R7 program refused", st, 8'h98);
        erase(18'h00200, st);
        ck("R7 erase refused", st, 8'hB8);
        wr(18'h0, 8'h90);
        rd(18'h0, v); ck("R7 id still works", v, 8'hA5);
        wr(18'h0, 8'hFF);
        rd(18'h00100, v); ck("R7 read still works", v, exp_rd('h100));
        wr(18'h0, 8'h50); wr(18'h0, 8'h70);
        rd(18'h0, v); ck("R7 clear still works", v, 8'h80);
        @(negedge clk); vpp_ok = 1;

        // R10/R11: suspend, mode change, resume
        prog(18'h20010, 8'h55, st); ref_prog('h20010, 8'h55);
        lat = 40;
        wr(18'h20000, 8'h20); wr(18'h20000, 8'hD0);
        rd(18'h0, v); ck("R11 busy status", v[7], 0);
        wr(18'h0, 8'hB0);
        rd(18'h0, v); ck("R10 suspended status", v, 8'hC0);
        ck("R10 hold high", arr_hold, 1);
        wr(18'h0, 8'hFF);
        rd(18'h20010, v); ck("R10 array read in suspend", v, 8'h55);
        wr(18'h0, 8'hD0);
        rd(18'h20010, v); ck("R11 busy read ignores array mode", v, 8'h00);
        ck("R10 hold released", arr_hold, 0);
        wr(18'h0, 8'h70);
        wait_rdy(st); ref_erase('h20000);
        ck("R10 resumed erase done", st, 8'h80);
        wr(18'h0, 8'hFF);
        rd(18'h20010, v); ck("R10 block erased", v, 8'hFF);
        lat = 6;

        // Collision: suspend write captured together with done
        manual = 1;
        wr(18'h00100, 8'h20); wr(18'h00100, 8'hD0);
        repeat (3) @(negedge clk);
        addr = 18'h0; din = 8'hB0; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); done_man = 1; ce_n = 1;
        @(negedge clk); done_man = 0;
        ref_erase('h100);
        manual = 0;
        rd(18'h0, v); ck("R10 done beats suspend", v, 8'h80);
        ck("R10 no hold after collision", arr_hold, 0);
        wr(18'h0, 8'hFF);
        rd(18'h00100, v); ck("R3 erase completed", v, 8'hFF);

        // Random programs over all blocks and both levels (R2, R5)
        for (int i = 0; i < 24; i++) begin
            int lo, hi, a;
            logic [7:0] d;
            bit hvsel;
            a = int'($urandom % 5);
            a = (a == 0) ? 'h00000 : (a == 1) ? 'h20000 : (a == 2) ? 'h38000 :
                (a == 3) ? 'h3A000 : 'h3C000;
            blk_range(a, lo, hi);
            a = lo + int'($urandom % 32'(hi - lo + 1));
            d = 8'($urandom);
            hvsel = 1'($urandom);
            @(negedge clk); rp_lvl = hvsel ? 2'b10 : 2'b01;
            prog(18'(a), d, st);
            if (a >= 'h3C000 && !hvsel) ck("R5 random locked", st, 8'h90);
            else begin ck("R2 random status", st, 8'h80); ref_prog(a, d); end
            wr(18'h0, 8'h50); wr(18'h0, 8'hFF);
            rd(18'(a), v); ck("R2 random readback", v, exp_rd(a));
        end

        // R8: reset clears errors and comes up in array mode
        @(negedge clk); rp_lvl = 2'b01;
        wr(18'h0, 8'h20); wr(18'h0, 8'h00);
        @(negedge clk); rp_lvl = 2'b00;
        repeat (3) @(negedge clk);
        power_up();
        rd(18'h00100, v); ck("R8 array mode after rise", v, exp_rd('h100));
        wr(18'h0, 8'h70);
        rd(18'h0, v); ck("R8 status cleared", v, 8'h80);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule